// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block takes one active-low external interrupt pin and turns it into a request for the interrupt logic. The pin passes through a synchronizer, which is a chain of flops set by a parameter. The request then comes from one of two sources. In level mode it follows the synchronized pin while the pin stays low. In edge mode it comes from a latch that a falling edge sets and that only reset or a service acknowledge clears.

One 8-bit control byte sets the behaviour. It holds an edge-select bit and a pin-connect bit. It is reached through a simple byte-wide register port at a module-relative offset. A mode input separates the special mode, where the edge-select bit can be rewritten freely, from the normal and emulation modes, where only the first write to it after reset counts. A reserved offset and all unmapped offsets read as zero and absorb writes.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset the control byte reads 0x40: bit 7 (edge select) = 0 and bit 6 (pin connect) = 1.
- R2: Bits 5..0 of the control byte always read 0, and writing them has no effect.
- R3: A read of the reserved offset (default 0x0F) or of any other offset apart from the control offset (default 0x1E) returns 0x00. Writes there change no state.
- R4: With edge select 0 and pin connect 1, `irq_req` is high exactly while the synchronized pin is low.
- R5: With edge select 1 and pin connect 1, a falling edge of the synchronized pin sets a latch. The latch drives `irq_req` high and holds it after the pin returns high.
- R6: `svc_ack` clears the edge latch. If a new falling edge is seen in the same cycle, the latch stays set.
- R7: While pin connect is 0, `irq_req` stays low, the edge latch is held clear, and edges seen while disconnected are not remembered.
- R8: In normal or emulation mode (`mode_special`=0), only the first control write after reset changes edge select. Pin connect stays writable at all times.
- R9: In special mode (`mode_special`=1), edge select can be written any number of times. These writes do not use up the one normal-mode write.
- R10: The pin reaches the request logic after SYNC_STAGES clock edges. A falling edge is a previous synchronized sample of 1 followed by a current sample of 0.
- R11: A register write is sampled on the clock edge where `bus_sel` and `bus_wr` are high, and it takes effect from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_special | input | 1 | 1 = special mode, 0 = normal/emulation |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Module-relative byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (0 when not reading the control offset) |
| irq_pin_n | input | 1 | Raw asynchronous active-low interrupt pin |
| svc_ack | input | 1 | Interrupt serviced, clears the edge latch |
| irq_req | output | 1 | Interrupt request to the interrupt logic |

## Verification
The bench builds the block with SYNC_STAGES = 3 rather than the default 2. This makes the synchronizer latency and the edge-detect window differ from the common case, so an off-by-one in the stage chain shows up as a mismatch every clock. The address width and both offsets keep their defaults, so the bench can reach the reserved offset and an unmapped offset next to the control offset. Mode switching in the middle of a run tests the write-once flag against special-mode rewrites.

// File: rtl/xirq_pkg.sv
// Package: shared constants and types for the external interrupt conditioner.
// Assumes an 8-bit register port; bit positions are decoded by software.
package xirq_pkg;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned EDGE_BIT   = 7;
    localparam int unsigned EN_BIT     = 6;
    localparam logic [DATA_W-1:0] CTRL_RESET = 8'h40;

    // Live control state held by the register.
    typedef struct packed {
        logic edge_sel;
        logic pin_en;
    } xirq_ctrl_t;

    // Pack control state into a register image; reserved bits read 0.
    function automatic logic [DATA_W-1:0] pack_ctrl(input xirq_ctrl_t c);
        logic [DATA_W-1:0] v;
        v           = '0;
        v[EDGE_BIT] = c.edge_sel;
        v[EN_BIT]   = c.pin_en;
        return v;
    endfunction
endpackage

// File: rtl/xirq_sync.sv
// Module: xirq_sync
// Brings the asynchronous pin into the clock domain through STAGES flops and
// reports the synchronized level plus a falling-edge strobe (prev 1, now 0).
// Assumes the pin idles high; reset loads all stages with 1.
module xirq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic level_n,
    output logic fall
);
    localparam int unsigned CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Shift the pin along the chain; one extra flop keeps the previous sample.
    generate
        for (genvar i = 0; i < CHAIN; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= pin_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    // Synchronized level and falling-edge detect.
    always_comb begin
        level_n = chain_q[STAGES-1];
        fall    = chain_q[STAGES] & ~chain_q[STAGES-1];
    end
endmodule

// File: rtl/xirq_ctlreg.sv
// Module: xirq_ctlreg
// Holds the edge-select and pin-connect bits. Edge select is write-once after
// reset outside special mode (hidden lock flag); pin connect always writable.
// Assumes wr_hit is already decoded for the control offset.
module xirq_ctlreg
    import xirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_special,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output xirq_ctrl_t        ctrl
);
    logic locked_q;

    // Update control bits and the write-once flag on a qualifying write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl.edge_sel <= CTRL_RESET[EDGE_BIT];
            ctrl.pin_en   <= CTRL_RESET[EN_BIT];
            locked_q      <= 1'b0;
        end else if (wr_hit) begin
            ctrl.pin_en <= wdata[EN_BIT];
            if (mode_special || !locked_q)
                ctrl.edge_sel <= wdata[EDGE_BIT];
            if (!mode_special)
                locked_q <= 1'b1;
        end
    end

    // R8: once locked, a normal-mode write leaves edge select unchanged.
    p_once_locks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && wr_hit && !mode_special) |=> $stable(ctrl.edge_sel));

    // R11: pin connect takes the written value from the write edge on.
    p_enable_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (ctrl.pin_en == $past(wdata[EN_BIT])));
endmodule

// File: rtl/xirq_edge.sv
// Module: xirq_edge
// Keeps the falling-edge latch and forms the request. The latch is set by an
// edge in edge mode, cleared by service (a new edge wins), and held clear
// while the pin is disconnected. Assumes fall is a single-cycle strobe.
module xirq_edge
    import xirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  xirq_ctrl_t ctrl,
    input  logic       level_n,
    input  logic       fall,
    input  logic       svc_ack,
    output logic       req
);
    logic latch_q;

    // Edge latch: disconnect forces clear, edge beats service.
    always_ff @(posedge clk) begin
        if (!rst_n)                         latch_q <= 1'b0;
        else if (!ctrl.pin_en)              latch_q <= 1'b0;
        else if (ctrl.edge_sel && fall)     latch_q <= 1'b1;
        else if (svc_ack)                   latch_q <= 1'b0;
    end

    // Request: gated by connect, chooses latch or live level.
    always_comb begin
        req = ctrl.pin_en & (ctrl.edge_sel ? latch_q : ~level_n);
    end

    // R5: a detected edge in edge mode sets the latch.
    p_edge_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.pin_en && ctrl.edge_sel && fall) |=> latch_q);

    // R5: without service the latch holds while connected.
    p_latch_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !svc_ack && ctrl.pin_en) |=> latch_q);

    // R6: service with no concurrent edge clears the latch.
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_ack && !(ctrl.edge_sel && fall)) |=> !latch_q);

    // R7: a disconnected pin leaves the latch clear on the next cycle.
    p_off_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ctrl.pin_en) |-> !latch_q);
endmodule

// File: rtl/xirq_ctrl.sv
// Module: xirq_ctrl (top)
// External interrupt conditioner: register decode, synchronizer, control
// register and edge latch. Reads are combinational; writes land on the edge
// where the strobe is sampled. Assumes a single byte-wide register port.
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 5,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 5'h1E,
    parameter logic [ADDR_W-1:0] RSVD_OFS = 5'h0F,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_special,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_pin_n,
    input  logic              svc_ack,
    output logic              irq_req
);
    xirq_ctrl_t ctrl;
    logic       wr_hit;
    logic       rd_hit;
    logic       level_n;
    logic       fall;

    // Address decode; the reserved offset decodes to nothing on purpose.
    always_comb begin
        wr_hit = bus_sel &  bus_wr & (bus_addr == CTRL_OFS);
        rd_hit = bus_sel & ~bus_wr & (bus_addr == CTRL_OFS) & (bus_addr != RSVD_OFS);
    end

    // Read mux: control image or zero.
    always_comb begin
        bus_rdata = rd_hit ? pack_ctrl(ctrl) : '0;
    end

    xirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (irq_pin_n),
        .level_n (level_n),
        .fall    (fall)
    );

    xirq_ctlreg u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_special (mode_special),
        .wr_hit       (wr_hit),
        .wdata        (bus_wdata),
        .ctrl         (ctrl)
    );

    xirq_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ctrl),
        .level_n (level_n),
        .fall    (fall),
        .svc_ack (svc_ack),
        .req     (irq_req)
    );

    // R3: accesses outside the control offset leave the control bits alone.
    p_rsvd_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr != CTRL_OFS) |=> $stable(ctrl));
endmodule

// File: tb/xirq_ctrl_bench.sv
// Bench: behavioural per-clock reference model compared on every falling edge.
module xirq_ctrl_bench;
    localparam int SYNC = 3;
    localparam logic [4:0] CTRL_A = 5'h1E;
    localparam logic [4:0] RSVD_A = 5'h0F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_special = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_pin_n = 1'b1;
    logic       svc_ack = 1'b0;
    logic       irq_req;

    always #2 clk = ~clk;   // 250 MHz

    xirq_ctrl #(.SYNC_STAGES(SYNC)) u_xirq_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_special(mode_special),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pin_n(irq_pin_n), .svc_ack(svc_ack), .irq_req(irq_req)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string tag = "R1";
    bit    done = 0;

    // Reference model state.
    bit m_edge, m_en, m_lock, m_latch;
    bit hist[$];

    always @(posedge clk) begin
        bit old_edge, old_en, f;
        cycles++;
        if (!rst_n) begin
            m_edge = 0; m_en = 1; m_lock = 0; m_latch = 0;
            hist = {};
            for (int i = 0; i <= SYNC; i++) hist.push_back(1'b1);
        end else begin
            old_edge = m_edge; old_en = m_en;
            f = hist[SYNC] & ~hist[SYNC-1];
            if (!old_en)                m_latch = 0;
            else if (old_edge && f)     m_latch = 1;
            else if (svc_ack)           m_latch = 0;
            if (bus_sel && bus_wr && bus_addr == CTRL_A) begin
                m_en = bus_wdata[6];
                if (mode_special || !m_lock) m_edge = bus_wdata[7];
                if (!mode_special) m_lock = 1;
            end
            hist.push_front(irq_pin_n);
            void'(hist.pop_back());
        end
    end

    // Compare outputs mid-cycle.
    always @(negedge clk) begin
        logic [7:0] exp_rd;
        logic       exp_req;
        if (rst_n && !done) begin
            exp_rd  = (bus_sel && !bus_wr && bus_addr == CTRL_A) ? {m_edge, m_en, 6'b0} : 8'h00;
            exp_req = m_en & (m_edge ? m_latch : ~hist[SYNC-1]);
            n_cmp++;
            if (bus_rdata !== exp_rd) begin
                n_bad++;
                $display("FAIL %s rdata actual=%h expected=%h t=%0t", tag, bus_rdata, exp_rd, $time);
            end
            n_cmp++;
            if (irq_req !== exp_req) begin
                n_bad++;
                $display("FAIL %s irq_req actual=%b expected=%b t=%0t", tag, irq_req, exp_req, $time);
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        tick();
        bus_sel = 0;
    endtask

    task automatic pulse_low(int n);
        irq_pin_n = 0; tick(n); irq_pin_n = 1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        tick(4);
        rst_n = 1;
        tick(1);
        tag = "R1"; rd(CTRL_A);
        tag = "R2"; mode_special = 1; wr(CTRL_A, 8'h7F); rd(CTRL_A);
        wr(CTRL_A, 8'h40); mode_special = 0;
        tag = "R3"; wr(RSVD_A, 8'hFF); rd(RSVD_A); wr(5'h1D, 8'h00); rd(5'h1D); rd(5'h1F); rd(CTRL_A);
        tag = "R4"; pulse_low(6); tick(6); pulse_low(1); tick(6);
        tag = "R10"; irq_pin_n = 0; tick(1); irq_pin_n = 1; tick(5);
        tag = "R9"; mode_special = 1;
        wr(CTRL_A, 8'hC0); rd(CTRL_A); wr(CTRL_A, 8'h40); rd(CTRL_A); wr(CTRL_A, 8'hC0); rd(CTRL_A);
        tag = "R5"; pulse_low(2); tick(8); rd(CTRL_A);
        tag = "R6"; svc_ack = 1; tick(1); svc_ack = 0; tick(3);
        irq_pin_n = 0; tick(SYNC); svc_ack = 1; tick(1); svc_ack = 0; irq_pin_n = 1; tick(6);
        svc_ack = 1; tick(2); svc_ack = 0; tick(3);
        tag = "R7"; pulse_low(2); tick(6); wr(CTRL_A, 8'h80); tick(3);
        pulse_low(2); tick(6); wr(CTRL_A, 8'hC0); tick(8);
        wr(CTRL_A, 8'h00); pulse_low(4); tick(6); wr(CTRL_A, 8'h40); tick(4);
        tag = "R8"; rst_n = 0; tick(2); rst_n = 1; mode_special = 0; tick(1);
        wr(CTRL_A, 8'hC0); rd(CTRL_A); wr(CTRL_A, 8'h40); rd(CTRL_A); wr(CTRL_A, 8'h80); rd(CTRL_A);
        wr(CTRL_A, 8'hC0); rd(CTRL_A);
        tag = "R11"; bus_sel = 1; bus_wr = 1; bus_addr = CTRL_A; bus_wdata = 8'h00;
        @(negedge clk); bus_sel = 1; tick(1); bus_sel = 0; bus_wr = 0; rd(CTRL_A);
        tag = "R9"; rst_n = 0; tick(2); rst_n = 1; mode_special = 1; tick(1);
        wr(CTRL_A, 8'hC0); wr(CTRL_A, 8'h40); mode_special = 0; wr(CTRL_A, 8'hC0); rd(CTRL_A);
        wr(CTRL_A, 8'h40); rd(CTRL_A);
        tag = "R4"; pulse_low(3); tick(6);
        finish_run();
    end

    // Watchdog.
    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end
endmodule